// File: doc/BRIEF.md
# Multiplexed Six-Digit BCD Time-of-Day Display

This block keeps a running time of day as six BCD digits: two for hours, two for minutes and two for seconds. It drives six common-anode seven-segment digits that share one segment bus. Two internal dividers run from the system clock. One makes the one-second tick that advances the time. The other makes the scan tick that moves the display from one digit to the next.

Only one digit is enabled at any moment. The enabled digit is marked by a single low line on the digit-select bus, and that low line rotates toward the more significant digits on every scan tick. The segment bus always carries the pattern for the digit whose select line is low. The decimal point is held dark. Both divider terminal counts are parameters, so a testbench can run a whole day in a short simulation.

Top module: `bcd_clock_scan`

## Requirements
- R1: While `rst_ni` is low, and directly after it rises, the outputs are `seg_o` = 8'hC0 and `dig_sel_o` = 6'b111110. The time is 00:00:00, and both dividers restart from zero.
- R2: `seg_o[6:0]` is active-low, with bit 6 = g down to bit 0 = a. The digits encode as 0=1000000, 1=1111001, 2=0100100, 3=0110000, 4=0011001, 5=0010010, 6=0000011, 7=1111000, 8=0000000 and 9=0010000. Any other code shows the pattern for 0.
- R3: `seg_o[7]`, the decimal point, is always 1 (dark).
- R4: `dig_sel_o` always has exactly one bit at 0. That zero rotates left by one position per scan tick, and a scan tick occurs every `SCAN_DIV` clock cycles. After E clock edges since reset, the zero is at bit (E / `SCAN_DIV`) mod 6.
- R5: The digits map to select bits as follows: bit 0 = seconds ones, bit 1 = seconds tens, bit 2 = minutes ones, bit 3 = minutes tens, bit 4 = hours ones, bit 5 = hours tens. `seg_o` and `dig_sel_o` change on the same edge. After E edges, `seg_o` shows the selected digit of the time as it stood after E-1 edges.
- R6: The time advances by one second every `SEC_DIV` cycles, so after E edges it holds (E / `SEC_DIV`) mod 86400 seconds. Seconds and minutes count 00 to 59 in BCD, and each carries into the next pair.
- R7: Hours count 00 to 23. On the carry out of 23:59:59 the time wraps to 00:00:00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| seg_o | output | 8 | Active-low segment bus: decimal point, then g down to a |
| dig_sel_o | output | 6 | Active-low digit select, one line low at a time |

## Verification
The bench uses a second divider of 2 and a scan divider of 3, which are coprime. As the run goes on, every select position meets every digit value, including the rare hours-tens values. A full day plus the wrap is compared cycle by cycle against a count-based model. This exposes an off-by-one in either divider, a select line that is out of step with the segment data, and a wrong carry or limit in each digit pair. A reset in the middle of the run checks that the dividers restart, rather than merely that the digits clear.

// File: rtl/bcd_clock_pkg.sv
package bcd_clock_pkg;
  localparam int unsigned NUM_DIGITS = 6;
  localparam int unsigned IDX_W      = $clog2(NUM_DIGITS);

  typedef logic [3:0] bcd_t;
  typedef logic [NUM_DIGITS-1:0][3:0] time_digits_t;

  // digit order: sec ones, sec tens, min ones, min tens, hr ones, hr tens
  localparam bcd_t DIGIT_MAX [NUM_DIGITS] = '{4'd9, 4'd5, 4'd9, 4'd5, 4'd9, 4'd2};
  localparam int unsigned HR_ONES = 4;
  localparam int unsigned HR_TENS = 5;

  // active-low g..a
  function automatic logic [6:0] seg7_encode(input bcd_t v);
    logic [6:0] p;
    case (v)
      4'd0:    p = 7'b100_0000;
      4'd1:    p = 7'b111_1001;
      4'd2:    p = 7'b010_0100;
      4'd3:    p = 7'b011_0000;
      4'd4:    p = 7'b001_1001;
      4'd5:    p = 7'b001_0010;
      4'd6:    p = 7'b000_0011;
      4'd7:    p = 7'b111_1000;
      4'd8:    p = 7'b000_0000;
      4'd9:    p = 7'b001_0000;
      default: p = 7'b100_0000;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/tick_div.sv
module tick_div #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/time_counter.sv
module time_counter
  import bcd_clock_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sec_tick_i,
  output time_digits_t digits_o
);
  time_digits_t digits_q, digits_d;

  always_comb begin
    logic carry;
    bcd_t lim;
    carry    = sec_tick_i;
    digits_d = digits_q;
    for (int i = 0; i < NUM_DIGITS; i++) begin
      lim = DIGIT_MAX[i];
      // hours ones stop at 3 when the tens digit is 2
      if (i == HR_ONES && digits_q[HR_TENS] == 4'd2) lim = 4'd3;
      if (carry) begin
        if (digits_q[i] >= lim) begin
          digits_d[i] = 4'd0;
        end else begin
          digits_d[i] = digits_q[i] + 4'd1;
          carry       = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) digits_q <= '0;
    else         digits_q <= digits_d;
  end

  assign digits_o = digits_q;
endmodule

// File: rtl/scan_mux.sv
module scan_mux
  import bcd_clock_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scan_tick_i,
  input  time_digits_t          digits_i,
  output logic [7:0]            seg_o,
  output logic [NUM_DIGITS-1:0] sel_o
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_DIGITS - 1);
  localparam logic [NUM_DIGITS-1:0] SEL_INIT = ~NUM_DIGITS'(1);

  logic [IDX_W-1:0]      idx_q, idx_d;
  logic [NUM_DIGITS-1:0] sel_q, sel_d;
  logic [7:0]            seg_q;

  always_comb begin
    idx_d = idx_q;
    sel_d = sel_q;
    if (scan_tick_i) begin
      idx_d = (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
      sel_d = {sel_q[NUM_DIGITS-2:0], sel_q[NUM_DIGITS-1]};
    end
  end

  // segment data looks up the next index so it lands with the new select
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      sel_q <= SEL_INIT;
      seg_q <= {1'b1, seg7_encode(4'd0)};
    end else begin
      idx_q <= idx_d;
      sel_q <= sel_d;
      seg_q <= {1'b1, seg7_encode(digits_i[idx_d])};
    end
  end

  assign seg_o = seg_q;
  assign sel_o = sel_q;
endmodule

// File: rtl/bcd_clock_scan.sv
module bcd_clock_scan
  import bcd_clock_pkg::*;
#(
  parameter int unsigned SEC_DIV  = 50_000_000,
  parameter int unsigned SCAN_DIV = 50_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  output logic [7:0] seg_o,
  output logic [5:0] dig_sel_o
);
  logic         sec_tick;
  logic         scan_tick;
  time_digits_t digits;

  tick_div #(.DIV(SEC_DIV)) i_sec_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (sec_tick)
  );

  tick_div #(.DIV(SCAN_DIV)) i_scan_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (scan_tick)
  );

  time_counter i_time (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sec_tick_i (sec_tick),
    .digits_o   (digits)
  );

  scan_mux i_scan (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .scan_tick_i (scan_tick),
    .digits_i    (digits),
    .seg_o       (seg_o),
    .sel_o       (dig_sel_o)
  );
endmodule

// File: rtl/bcd_clock_scan_chk.sv
module bcd_clock_scan_chk
  import bcd_clock_pkg::*;
(
  input logic         clk_i,
  input logic         rst_ni,
  input logic [7:0]   seg_o,
  input logic [5:0]   dig_sel_o,
  input logic         sec_tick,
  input time_digits_t digits
);
  // R3
  dp_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_o[7] == 1'b1);

  // R4
  one_sel_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~dig_sel_o) == 1);

  // R4
  sel_rotate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dig_sel_o != $past(dig_sel_o)) |->
      (dig_sel_o == {$past(dig_sel_o[4:0]), $past(dig_sel_o[5])}));

  // R6
  time_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(sec_tick) |-> $stable(digits));

  // R6
  sec_min_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    digits[0] <= 4'd9 && digits[1] <= 4'd5 && digits[2] <= 4'd9 && digits[3] <= 4'd5);

  // R7
  hour_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    digits[5] <= 4'd2 && (digits[5] != 4'd2 || digits[4] <= 4'd3));
endmodule

bind bcd_clock_scan bcd_clock_scan_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .seg_o     (seg_o),
  .dig_sel_o (dig_sel_o),
  .sec_tick  (sec_tick),
  .digits    (digits)
);

// File: tb/test_bcd_clock_scan.sv
`timescale 1ns/1ps
module test_bcd_clock_scan;
  localparam int SD = 2;
  localparam int SC = 3;
  localparam int DAY = 86400;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] seg;
  logic [5:0] sel;

  int checks = 0;
  int fails  = 0;
  int edges  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  bcd_clock_scan #(.SEC_DIV(SD), .SCAN_DIV(SC)) i_bcd_clock_scan (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .seg_o     (seg),
    .dig_sel_o (sel)
  );

  always @(posedge clk) begin
    if (!rst_n) edges <= 0;
    else        edges <= edges + 1;
  end

  function automatic logic [6:0] enc(input int v);
    case (v)
      0: return 7'b1000000;
      1: return 7'b1111001;
      2: return 7'b0100100;
      3: return 7'b0110000;
      4: return 7'b0011001;
      5: return 7'b0010010;
      6: return 7'b0000011;
      7: return 7'b1111000;
      8: return 7'b0000000;
      9: return 7'b0010000;
      default: return 7'b1000000;
    endcase
  endfunction

  function automatic int digit_of(input int t, input int p);
    int s, m, h;
    s = t % 60; m = (t / 60) % 60; h = t / 3600;
    case (p)
      0: return s % 10;
      1: return s / 10;
      2: return m % 10;
      3: return m / 10;
      4: return h % 10;
      default: return h / 10;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      if (fails < 20)
        $display("FAIL %s edge=%0d actual=%0h expected=%0h", tag, edges, act, exp);
    end
  endtask

  task automatic check_cycle();
    int p, t;
    logic [5:0] esel;
    logic [7:0] eseg;
    p = (edges / SC) % 6;
    t = ((edges > 0 ? edges - 1 : 0) / SD) % DAY;
    esel = ~(6'b1 << p);
    eseg = {1'b1, enc(digit_of(t, p))};
    check(sel == esel, "R4 select", sel, esel);
    check(seg[7] == 1'b1, "R3 dp", seg[7], 1);
    if (p < 2)      check(seg == eseg, "R2 R5 R6 sec digit", seg, eseg);
    else if (p < 4) check(seg == eseg, "R5 R6 min digit", seg, eseg);
    else            check(seg == eseg, "R5 R7 hour digit", seg, eseg);
  endtask

  task automatic check_reset();
    check(seg == 8'hC0, "R1 seg reset", seg, 8'hC0);
    check(sel == 6'b111110, "R1 sel reset", sel, 6'b111110);
  endtask

  initial begin : watchdog
    repeat (195000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check_reset();
    rst_n = 1'b1;
    for (int k = 0; k < 500; k++) begin
      @(negedge clk);
      check_cycle();
    end
    // mid-run reset: dividers and time restart (R1)
    rst_n = 1'b0;
    #1;
    check_reset();
    repeat (2) @(negedge clk);
    check_reset();
    rst_n = 1'b1;
    #1;
    check_reset();
    // full day plus the wrap (R7)
    for (int k = 0; k < DAY * SD + 40; k++) begin
      @(negedge clk);
      check_cycle();
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule